// File: doc/BRIEF.md
# Privileged-Mode Trap Sequencer with Shadow Registers

This block decides where the program counter goes when a fault is raised, when a handler returns, and when the core simply advances. It holds the program counter, a writable handler base and a saved return address. It also holds a 32-entry integer register file in which eight registers (8 to 14 and 25) each have a shadow copy. Bit 0 of the program counter marks privileged mode. Every handler entry point is the handler base plus an odd per-fault offset, so entering a handler sets that bit.

A fault taken from normal mode, or a return whose target has bit 0 clear, starts a bank exchange. A two-state machine then walks the eight shadow slots, exchanging one live register with its shadow copy per cycle. The states are RUN and SWAP. There are three transitions. RUN goes to SWAP when an entry or exit needs an exchange. SWAP goes to SWAP while slots remain. SWAP goes back to RUN after the last slot, where it records which bank is now live. While SWAP is active the block reports busy and ignores control requests and register writes. The surrounding core uses the read port, the write port and the program counter output as its view of architectural state.

Top module: `trap_seq`

## Requirements
- R1: After reset the program counter is the reset handler base (default 0x0001_0000) plus 0x0001. The block is privileged and the shadow bank is live. The return address is 0, busy, interrupt-enable and the error flag are 0, and every register reads 0.
- R2: A fault sends the program counter to handler base plus the offset for its code. The codes are 0 interrupt 0x0101, 1 machine check 0x0401, 2 arithmetic 0x0501, 3 alignment 0x0301, 4 unimplemented opcode 0x0481, 5 privileged call 0x2001, 6 integer overflow 0x0501 and 7 (spare) 0x0401.
- R3: A fault saves the current program counter as the return address. For codes 2 and 5 it saves the program counter plus 4 instead.
- R4: An interrupt (code 0) taken while privileged leaves the return address unchanged.
- R5: A fault taken from normal mode makes busy high for exactly 8 cycles. After that, registers 8–14 and 25 hold their former shadow values and the shadows hold the former live values. No other register changes.
- R6: A fault taken while already privileged starts no exchange, and busy stays low.
- R7: A return request while not privileged acts as an unimplemented-opcode fault (code 4 rules, including the exchange).
- R8: A return request while privileged loads the return address into the program counter. The banks are exchanged back only when bit 0 of that address is 0.
- R9: Interrupt-enable falls on every fault entry and rises on every privileged return.
- R10: With no fault or return, a step request adds 4 to the program counter. A fault takes priority over a return, which takes priority over a step.
- R11: While busy, fault, return, step and register-write requests are ignored. A handler-base write is still accepted.
- R12: A request to make the already-live bank live sets the sticky error flag and exchanges nothing. No legal sequence of requests produces it, so the flag stays 0.
- R13: A handler-base write stores the value with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Advance the program counter by one instruction |
| fault_valid_i | input | 1 | Raise a fault this cycle |
| fault_code_i | input | 3 | Fault code (see R2) |
| ret_i | input | 1 | Return-from-handler request |
| base_we_i | input | 1 | Write the handler base |
| base_wdata_i | input | XLEN | New handler base |
| rf_we_i | input | 1 | Register write enable |
| rf_waddr_i | input | AW | Register write index |
| rf_wdata_i | input | XLEN | Register write data |
| rf_raddr_i | input | AW | Register read index |
| rf_rdata_o | output | XLEN | Live value of the read register |
| pc_o | output | XLEN | Program counter |
| epc_o | output | XLEN | Saved return address |
| priv_o | output | 1 | Privileged mode (program counter bit 0) |
| busy_o | output | 1 | Bank exchange in progress |
| intr_en_o | output | 1 | Interrupt checking enabled |
| swap_err_o | output | 1 | Sticky bank-state error |

## Verification
The checker watches every cycle for the following:
- the program counter and return address staying frozen while busy;
- no exchange starting when a fault arrives in privileged mode;
- a privileged interrupt never touching the return address;
- a privileged return landing on the saved address and re-enabling interrupts;
- no exchange outlasting eight cycles;
- the error flag staying low.

Only the bench's scenarios can show the following, because each depends on history that a single cycle cannot reveal:
- which values end up in registers 8–14 and 25 after an exchange, and that the others are untouched;
- the exact offset and skip for each code;
- the return-outside-privilege fault;
- writes being dropped during busy;
- base masking.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    typedef enum logic [2:0] {
        FC_INTR  = 3'd0,
        FC_MCHK  = 3'd1,
        FC_ARITH = 3'd2,
        FC_ALIGN = 3'd3,
        FC_UNIMP = 3'd4,
        FC_PCALL = 3'd5,
        FC_OVFL  = 3'd6,
        FC_SPARE = 3'd7
    } fault_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_SWAP = 1'b1
    } state_e;

    localparam int OFS_W = 16;

    localparam logic [OFS_W-1:0] OFS_RESET = 16'h0001;
    localparam logic [OFS_W-1:0] OFS_INTR  = 16'h0101;
    localparam logic [OFS_W-1:0] OFS_MCHK  = 16'h0401;
    localparam logic [OFS_W-1:0] OFS_ARITH = 16'h0501;
    localparam logic [OFS_W-1:0] OFS_ALIGN = 16'h0301;
    localparam logic [OFS_W-1:0] OFS_UNIMP = 16'h0481;
    localparam logic [OFS_W-1:0] OFS_PCALL = 16'h2001;

endpackage

// File: rtl/trap_seq_vec.sv
module trap_seq_vec
    import trap_seq_pkg::*;
(
    input  logic [2:0]       code_i,
    output logic [OFS_W-1:0] ofs_o,
    output logic             skip_o
);

    fault_e code;
    assign code = fault_e'(code_i);

    always_comb begin
        ofs_o  = OFS_MCHK;
        skip_o = 1'b0;
        unique case (code)
            FC_INTR:  ofs_o = OFS_INTR;
            FC_MCHK:  ofs_o = OFS_MCHK;
            FC_ARITH: begin
                ofs_o  = OFS_ARITH;
                skip_o = 1'b1;
            end
            FC_ALIGN: ofs_o = OFS_ALIGN;
            FC_UNIMP: ofs_o = OFS_UNIMP;
            FC_PCALL: begin
                ofs_o  = OFS_PCALL;
                skip_o = 1'b1;
            end
            FC_OVFL:  ofs_o = OFS_ARITH;
            FC_SPARE: ofs_o = OFS_MCHK;
        endcase
    end

endmodule

// File: rtl/trap_seq_regs.sv
module trap_seq_regs #(
    parameter int XLEN         = 32,
    parameter int NREGS        = 32,
    parameter int NSHADOW      = 8,
    parameter int SHADOW_LO    = 8,
    parameter int SHADOW_EXTRA = 25,
    localparam int AW = $clog2(NREGS),
    localparam int SW = $clog2(NSHADOW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [AW-1:0]   raddr_i,
    output logic [XLEN-1:0] rdata_o,
    input  logic            swap_en_i,
    input  logic [SW-1:0]   swap_slot_i
);

    logic [XLEN-1:0] live_q   [NREGS];
    logic [XLEN-1:0] shadow_q [NSHADOW];

    // slot k < NSHADOW-1 maps to SHADOW_LO+k; the last slot maps to SHADOW_EXTRA
    function automatic logic [AW-1:0] slot_reg(input logic [SW-1:0] slot);
        if (int'(slot) < NSHADOW - 1)
            return AW'(SHADOW_LO + int'(slot));
        else
            return AW'(SHADOW_EXTRA);
    endfunction

    logic [AW-1:0] swap_reg;
    assign swap_reg = slot_reg(swap_slot_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++)   live_q[i]   <= '0;
            for (int s = 0; s < NSHADOW; s++) shadow_q[s] <= '0;
        end else if (swap_en_i) begin
            live_q[swap_reg]      <= shadow_q[swap_slot_i];
            shadow_q[swap_slot_i] <= live_q[swap_reg];
        end else if (we_i) begin
            live_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = live_q[raddr_i];

endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_seq_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              NREGS        = 32,
    parameter int              NSHADOW      = 8,
    parameter int              SHADOW_LO    = 8,
    parameter int              SHADOW_EXTRA = 25,
    parameter logic [XLEN-1:0] RESET_BASE   = 32'h0001_0000,
    localparam int AW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic            fault_valid_i,
    input  logic [2:0]      fault_code_i,
    input  logic            ret_i,
    input  logic            base_we_i,
    input  logic [XLEN-1:0] base_wdata_i,
    input  logic            rf_we_i,
    input  logic [AW-1:0]   rf_waddr_i,
    input  logic [XLEN-1:0] rf_wdata_i,
    input  logic [AW-1:0]   rf_raddr_i,
    output logic [XLEN-1:0] rf_rdata_o,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] epc_o,
    output logic            priv_o,
    output logic            busy_o,
    output logic            intr_en_o,
    output logic            swap_err_o
);

    localparam int              SW         = $clog2(NSHADOW);
    localparam logic [SW-1:0]   LAST_SLOT  = SW'(NSHADOW - 1);
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);
    localparam logic [XLEN-1:0] BASE_MASK  = ~XLEN'(3);

    state_e          state_q, state_d;
    logic [SW-1:0]   slot_q, slot_d;
    logic            tgt_q, tgt_d;
    logic            sh_live_q, sh_live_d;
    logic [XLEN-1:0] pc_q, pc_d;
    logic [XLEN-1:0] epc_q, epc_d;
    logic [XLEN-1:0] base_q, base_d;
    logic            ien_q, ien_d;
    logic            err_q, err_d;

    logic            in_priv;
    logic            take_fault, ret_bad, ret_ok;
    logic [2:0]      eff_code;
    logic [OFS_W-1:0] vec_ofs;
    logic            vec_skip;
    logic            swap_req;
    logic            swap_tgt;

    assign in_priv    = pc_q[0];
    assign take_fault = (state_q == ST_RUN) && (fault_valid_i || (ret_i && !in_priv));
    assign ret_bad    = (state_q == ST_RUN) && !fault_valid_i && ret_i && !in_priv;
    assign ret_ok     = (state_q == ST_RUN) && !fault_valid_i && ret_i && in_priv;
    assign eff_code   = ret_bad ? 3'(FC_UNIMP) : fault_code_i;

    trap_seq_vec u_vec (
        .code_i (eff_code),
        .ofs_o  (vec_ofs),
        .skip_o (vec_skip)
    );

    trap_seq_regs #(
        .XLEN         (XLEN),
        .NREGS        (NREGS),
        .NSHADOW      (NSHADOW),
        .SHADOW_LO    (SHADOW_LO),
        .SHADOW_EXTRA (SHADOW_EXTRA)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (rf_we_i && (state_q == ST_RUN)),
        .waddr_i     (rf_waddr_i),
        .wdata_i     (rf_wdata_i),
        .raddr_i     (rf_raddr_i),
        .rdata_o     (rf_rdata_o),
        .swap_en_i   (state_q == ST_SWAP),
        .swap_slot_i (slot_q)
    );

    // exchange request: into shadows on entry from normal mode,
    // out of shadows on a return whose target has bit 0 clear
    always_comb begin
        swap_req = 1'b0;
        swap_tgt = 1'b0;
        if (take_fault && !in_priv) begin
            swap_req = 1'b1;
            swap_tgt = 1'b1;
        end else if (ret_ok && !epc_q[0]) begin
            swap_req = 1'b1;
            swap_tgt = 1'b0;
        end
    end

    // next-state and datapath
    always_comb begin
        state_d   = state_q;
        slot_d    = slot_q;
        tgt_d     = tgt_q;
        sh_live_d = sh_live_q;
        pc_d      = pc_q;
        epc_d     = epc_q;
        ien_d     = ien_q;
        err_d     = err_q;
        base_d    = base_we_i ? (base_wdata_i & BASE_MASK) : base_q;

        unique case (state_q)
            ST_RUN: begin
                if (take_fault) begin
                    pc_d  = base_q + XLEN'(vec_ofs);
                    ien_d = 1'b0;
                    if (!(fault_e'(eff_code) == FC_INTR && in_priv))
                        epc_d = vec_skip ? (pc_q + INSN_BYTES) : pc_q;
                end else if (ret_ok) begin
                    pc_d  = epc_q;
                    ien_d = 1'b1;
                end else if (step_i) begin
                    pc_d = pc_q + INSN_BYTES;
                end

                if (swap_req) begin
                    if (swap_tgt == sh_live_q) begin
                        err_d = 1'b1;
                    end else begin
                        state_d = ST_SWAP;
                        slot_d  = '0;
                        tgt_d   = swap_tgt;
                    end
                end
            end

            ST_SWAP: begin
                if (slot_q == LAST_SLOT) begin
                    state_d   = ST_RUN;
                    sh_live_d = tgt_q;
                    slot_d    = '0;
                end else begin
                    slot_d = slot_q + SW'(1);
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            slot_q    <= '0;
            tgt_q     <= 1'b0;
            sh_live_q <= 1'b1;
        end else begin
            state_q   <= state_d;
            slot_q    <= slot_d;
            tgt_q     <= tgt_d;
            sh_live_q <= sh_live_d;
        end
    end

    // architectural registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= (RESET_BASE & BASE_MASK) + XLEN'(OFS_RESET);
            epc_q  <= '0;
            base_q <= RESET_BASE & BASE_MASK;
            ien_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            epc_q  <= epc_d;
            base_q <= base_d;
            ien_q  <= ien_d;
            err_q  <= err_d;
        end
    end

    assign pc_o       = pc_q;
    assign epc_o      = epc_q;
    assign priv_o     = pc_q[0];
    assign busy_o     = (state_q == ST_SWAP);
    assign intr_en_o  = ien_q;
    assign swap_err_o = err_q;

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
    parameter int XLEN    = 32,
    parameter int NSHADOW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fault_valid_i,
    input logic [2:0]      fault_code_i,
    input logic            ret_i,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] epc_o,
    input logic            priv_o,
    input logic            busy_o,
    input logic            intr_en_o,
    input logic            swap_err_o
);

    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_run <= 0;
        else if (busy_o) busy_run <= busy_run + 1;
        else             busy_run <= 0;
    end

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(pc_o) && $stable(epc_o)));

    // R12
    no_swap_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_err_o);

    // R4
    intr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid_i && !busy_o && priv_o && fault_code_i == 3'd0) |=> $stable(epc_o));

    // R6
    priv_noswap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid_i && !busy_o && priv_o) |=> !busy_o);

    // R8
    ret_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !fault_valid_i && !busy_o && priv_o) |=> (pc_o == $past(epc_o)));

    // R9
    ret_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !fault_valid_i && !busy_o && priv_o) |=> intr_en_o);

    // R9
    fault_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid_i && !busy_o) |=> !intr_en_o);

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_run < NSHADOW));

    // R5
    user_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid_i && !busy_o && !priv_o) |=> (busy_o && priv_o));

endmodule

bind trap_seq trap_seq_chk #(.XLEN(XLEN), .NSHADOW(NSHADOW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_valid_i (fault_valid_i),
    .fault_code_i  (fault_code_i),
    .ret_i         (ret_i),
    .pc_o          (pc_o),
    .epc_o         (epc_o),
    .priv_o        (priv_o),
    .busy_o        (busy_o),
    .intr_en_o     (intr_en_o),
    .swap_err_o    (swap_err_o)
);

// File: tb/trap_seq_tb.sv
`timescale 1ns/1ps
module trap_seq_tb;

    localparam int XLEN = 32;
    localparam int NREGS = 32;
    localparam int NSH = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            step_i = 1'b0, fault_valid_i = 1'b0, ret_i = 1'b0;
    logic [2:0]      fault_code_i = 3'd0;
    logic            base_we_i = 1'b0;
    logic [XLEN-1:0] base_wdata_i = '0;
    logic            rf_we_i = 1'b0;
    logic [4:0]      rf_waddr_i = '0, rf_raddr_i = '0;
    logic [XLEN-1:0] rf_wdata_i = '0;
    logic [XLEN-1:0] rf_rdata_o, pc_o, epc_o;
    logic            priv_o, busy_o, intr_en_o, swap_err_o;

    always #4 clk = ~clk;

    trap_seq u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .fault_valid_i(fault_valid_i),
        .fault_code_i(fault_code_i), .ret_i(ret_i), .base_we_i(base_we_i),
        .base_wdata_i(base_wdata_i), .rf_we_i(rf_we_i), .rf_waddr_i(rf_waddr_i),
        .rf_wdata_i(rf_wdata_i), .rf_raddr_i(rf_raddr_i), .rf_rdata_o(rf_rdata_o),
        .pc_o(pc_o), .epc_o(epc_o), .priv_o(priv_o), .busy_o(busy_o),
        .intr_en_o(intr_en_o), .swap_err_o(swap_err_o)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [XLEN-1:0] m_pc, m_epc, m_base;
    logic            m_ien;
    logic [XLEN-1:0] m_live [NREGS];
    logic [XLEN-1:0] m_shd  [NSH];

    function automatic logic [XLEN-1:0] exp_ofs(input logic [2:0] c);
        case (c)
            3'd0: return 32'h0101;
            3'd1: return 32'h0401;
            3'd2: return 32'h0501;
            3'd3: return 32'h0301;
            3'd4: return 32'h0481;
            3'd5: return 32'h2001;
            3'd6: return 32'h0501;
            default: return 32'h0401;
        endcase
    endfunction

    function automatic int exp_reg(input int s);
        return (s < NSH - 1) ? 8 + s : 25;
    endfunction

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_swap();
        for (int s = 0; s < NSH; s++) begin
            logic [XLEN-1:0] t;
            t = m_live[exp_reg(s)];
            m_live[exp_reg(s)] = m_shd[s];
            m_shd[s] = t;
        end
    endtask

    // inputs already driven at a negedge; wait one edge, clear, then count busy
    task automatic finish_op(input string req, input bit exp_swap, input bit noise);
        int n;
        @(negedge clk);
        step_i = 0; fault_valid_i = 0; ret_i = 0; rf_we_i = 0; base_we_i = 0;
        n = 0;
        while (busy_o && n < 40) begin
            if (noise) begin
                step_i = 1; fault_valid_i = 1; ret_i = 1; fault_code_i = 3'd1;
                rf_we_i = 1; rf_waddr_i = 5'd3; rf_wdata_i = 32'hDEAD_0003;
                base_we_i = 1; base_wdata_i = 32'h0004_0002;
            end
            n++;
            @(negedge clk);
        end
        if (noise) begin
            step_i = 0; fault_valid_i = 0; ret_i = 0; rf_we_i = 0; base_we_i = 0;
            m_base = 32'h0004_0000;
        end
        chk({req, " busy cycles"}, XLEN'(n), exp_swap ? XLEN'(NSH) : '0);
        if (exp_swap) model_swap();
        chk({req, " pc"}, pc_o, m_pc);
        chk({req, " epc"}, epc_o, m_epc);
        chk({req, " priv"}, XLEN'(priv_o), XLEN'(m_pc[0]));
        chk({req, " ien"}, XLEN'(intr_en_o), XLEN'(m_ien));
    endtask

    task automatic model_fault(input logic [2:0] c, output bit sw);
        bit pv;
        pv = m_pc[0];
        if (!(c == 3'd0 && pv))
            m_epc = m_pc + ((c == 3'd2 || c == 3'd5) ? 32'd4 : 32'd0);
        m_pc  = m_base + exp_ofs(c);
        m_ien = 0;
        sw    = !pv;
    endtask

    task automatic do_fault(input string req, input logic [2:0] c, input bit noise);
        bit sw;
        @(negedge clk);
        fault_valid_i = 1; fault_code_i = c;
        model_fault(c, sw);
        finish_op(req, sw, noise);
    endtask

    task automatic do_ret(input string req);
        bit sw;
        @(negedge clk);
        ret_i = 1;
        if (!m_pc[0]) begin
            model_fault(3'd4, sw);
        end else begin
            sw = !m_epc[0];
            m_pc = m_epc;
            m_ien = 1;
        end
        finish_op(req, sw, 0);
    endtask

    task automatic do_step();
        @(negedge clk);
        step_i = 1;
        m_pc = m_pc + 4;
        finish_op("R10 step", 0, 0);
    endtask

    task automatic do_wr(input logic [4:0] a, input logic [XLEN-1:0] d);
        @(negedge clk);
        rf_we_i = 1; rf_waddr_i = a; rf_wdata_i = d;
        m_live[a] = d;
        @(negedge clk);
        rf_we_i = 0;
    endtask

    task automatic do_base(input logic [XLEN-1:0] d);
        @(negedge clk);
        base_we_i = 1; base_wdata_i = d;
        m_base = d & ~32'd3;
        @(negedge clk);
        base_we_i = 0;
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREGS; i++) begin
            rf_raddr_i = 5'(i);
            #0.1;
            chk(req, rf_rdata_o, m_live[i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_base = 32'h0001_0000;
        m_pc   = 32'h0001_0001;
        m_epc  = '0;
        m_ien  = 0;
        for (int i = 0; i < NREGS; i++) m_live[i] = '0;
        for (int s = 0; s < NSH; s++)  m_shd[s]  = '0;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pc", pc_o, 32'h0001_0001);
        chk("R1 priv", XLEN'(priv_o), 32'd1);
        chk("R1 epc", epc_o, '0);
        chk("R1 busy", XLEN'(busy_o), '0);
        chk("R1 ien", XLEN'(intr_en_o), '0);
        chk("R1 err", XLEN'(swap_err_o), '0);
        check_regs("R1 regs");

        // fill the live (shadow-bank) copies while privileged
        for (int i = 0; i < NREGS; i++) do_wr(5'(i), 32'hA000_0000 + 32'(i));
        do_ret("R8 return to user");          // epc=0 -> bit0 clear -> exchange
        check_regs("R5 regs after exit exchange");
        for (int i = 8; i < 15; i++) do_wr(5'(i), 32'hB000_0000 + 32'(i));
        do_wr(5'd25, 32'hB000_0025);
        do_step();
        do_fault("R3 R2 arith from user", 3'd2, 0);
        check_regs("R5 regs after entry exchange");
        do_fault("R4 R6 interrupt in priv", 3'd0, 0);
        do_fault("R3 R6 align in priv", 3'd3, 0);  // epc gets odd pc
        do_ret("R8 return keeps priv");            // epc bit0 set -> no exchange
        chk("R8 still priv", XLEN'(priv_o), 32'd1);
        do_fault("R4 interrupt priv", 3'd0, 0);
        check_regs("R6 no exchange in priv");

        // reach user mode, then a return there is an unimplemented-opcode fault
        do_fault("R3 pcall priv", 3'd5, 0);
        m_epc = m_epc;
        do_base(32'h0002_0003);                    // R13 low bits dropped
        do_fault("R13 base masked", 3'd1, 0);
        // produce a user return address: go to user through a reset-like path
        do_ret("R8 priv return");
        while (m_pc[0]) begin
            // epc odd: take a fault from user not possible yet; walk through pcall and clear via user fault
            do_fault("R2 mchk priv", 3'd1, 0);
            do_ret("R8 priv return loop");
            if (m_pc[0]) begin
                // force a user-mode return address by returning to epc written from reset path
                break;
            end
        end

        // directed: reset again to get back to a known user entry
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        m_base = 32'h0001_0000; m_pc = 32'h0001_0001; m_epc = '0; m_ien = 0;
        for (int i = 0; i < NREGS; i++) m_live[i] = '0;
        for (int s = 0; s < NSH; s++)  m_shd[s]  = '0;
        @(negedge clk);
        chk("R1 pc after second reset", pc_o, 32'h0001_0001);
        do_ret("R8 exit after reset");
        do_ret("R7 return in user");
        chk("R7 pc", pc_o, 32'h0001_0481);
        do_ret("R8 back to user");

        // R2 every code from user mode
        for (int c = 0; c < 8; c++) begin
            do_step();
            do_fault("R2 R3 code sweep", 3'(c), 0);
            do_ret("R8 sweep return");
        end

        // R10 priority
        @(negedge clk);
        fault_valid_i = 1; fault_code_i = 3'd3; ret_i = 1; step_i = 1;
        begin bit sw; model_fault(3'd3, sw); finish_op("R10 fault over ret", sw, 0); end
        @(negedge clk);
        ret_i = 1; step_i = 1;
        begin bit sw; sw = !m_epc[0]; m_pc = m_epc; m_ien = 1; finish_op("R10 ret over step", sw, 0); end

        // R11 noise during exchange
        do_wr(5'd3, 32'h0000_0333);
        do_fault("R11 ignored while busy", 3'd1, 1);
        check_regs("R11 regs untouched during busy");
        do_fault("R11 new base in effect", 3'd3, 0);

        // random phase
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0, 1: do_step();
                2, 3: do_wr(5'($urandom_range(0, 31)), $urandom());
                4, 5: do_fault("R2 R3 random fault", 3'($urandom_range(0, 7)), 0);
                6, 7: do_ret("R8 R7 random return");
                8:    do_base({16'($urandom()), 14'd0, 2'($urandom())});
                default: check_regs("R5 random regs");
            endcase
        end
        check_regs("R5 final regs");
        chk("R12 err flag", XLEN'(swap_err_o), '0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule